// File: doc/BRIEF.md
# Scalar Execute Unit with Sticky Condition Flags

This block is the integer execute stage of a small load/store processor. Each cycle it takes an opcode, two register operands, a sign-extended immediate and the program counter, and it produces one result word without delay. The result covers arithmetic, bitwise logic, shifts, effective addresses, jump targets and resolved branch targets. Four condition flags are held in registers and change only on a clock edge where the valid strobe is high. The flags are positive overflow, negative overflow, greater-than and equal.

Conditional branches read the stored flags. The unit reports a taken branch by presenting the target word together with a taken bit. A not-taken branch returns a word of all ones. A divide by a zero divisor raises a halt output and returns the largest positive value. An opcode outside the defined set raises an illegal-operation output. The unit holds no state besides the flag register.

Top module: `exu_core`

## Requirements
- R1: ADD (0), SUB (1), MUL (2), ADDI (12, A+imm) and SUBI (13, A−imm) output the low XLEN bits of the exact signed result. On a valid edge they set flags[0] (positive overflow) if the exact result exceeds the largest positive value, and set flags[1] (negative overflow) if it falls below the most negative value. Each flag is cleared when its condition does not hold.
- R2: AND (7), OR (8), XOR (9) and their immediate forms ANDI (16), ORI (17), XORI (18) operate bitwise on A and on B or imm. NOT (10) outputs the inverse of A. All of these clear flags[0] and flags[1] on a valid edge.
- R3: SHR (5) is an arithmetic right shift and SHL (6) a left shift of A by the low 5 bits of B. SHRI (14) and SHLI (15) shift by the low 5 bits of imm. All four leave every flag unchanged.
- R4: CMP (11) sets flags[2] when A > B as signed values and sets flags[3] when A == B, clearing each flag otherwise. It outputs A unchanged and leaves flags[0] and flags[1] unchanged.
- R5: LOAD (19), STORE (20), PUSH (21) and POP (22) output A+imm. JMP (23) and JAL (24) output A+B. JREL (25) outputs PC+B. None of these touch any flag.
- R6: Branch opcodes BRE (26), BRG (27), BRU (28) and BRO (29) test flags[3], flags[2], flags[1] and flags[0] respectively. When the tested flag is set, the unit outputs PC+B with br_taken=1. Otherwise it outputs all ones with br_taken=0. No flag changes.
- R7: QUO (3) and REM (4) output the signed quotient and remainder, truncated toward zero, and clear flags[0] and flags[1]. When the dividend is the most negative value and the divisor is −1, both opcodes output the most negative value and set flags[0].
- R8: For QUO or REM with B == 0, the unit outputs the largest positive value (0x7FFF_FFFF at XLEN=32), asserts halt while valid is high, and leaves all flags unchanged.
- R9: Opcodes 32–63 assert illegal while valid is high, output A unchanged and leave every flag unchanged. RET (30) and NOP (31) also output A and change no flag.
- R10: Synchronous reset clears all four flags. While valid is low, the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Operation strobe; flags update only when high |
| opcode | input | 6 | Operation code |
| op_a | input | XLEN | First register operand |
| op_b | input | XLEN | Second register operand / branch offset |
| imm | input | XLEN | Sign-extended immediate |
| pc | input | XLEN | Program counter of the operation |
| result | output | XLEN | Result word (combinational) |
| br_taken | output | 1 | Branch condition held |
| halt | output | 1 | Divide by zero while valid |
| illegal | output | 1 | Unrecognised opcode while valid |
| flags | output | 4 | {equal, greater, neg-overflow, pos-overflow} |

## Verification
The bench builds the unit with XLEN at its default of 32. At this width, 0x7FFF_FFFF and 0x8000_0000 are exact 32-bit values, so directed cases can hit the overflow edges of add, subtract and multiply and the most-negative ÷ −1 case exactly. The bench model uses 64-bit arithmetic, which holds every exact product without loss. Every possible 5-bit shift amount can be reached, and random operands bias toward zero, ±1 and the two extremes. The random stream therefore lands on zero divisors and on branches after each flag state.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [5:0] {
        OPC_ADD  = 6'd0,  OPC_SUB  = 6'd1,  OPC_MUL  = 6'd2,  OPC_QUO  = 6'd3,
        OPC_REM  = 6'd4,  OPC_SHR  = 6'd5,  OPC_SHL  = 6'd6,  OPC_AND  = 6'd7,
        OPC_OR   = 6'd8,  OPC_XOR  = 6'd9,  OPC_NOT  = 6'd10, OPC_CMP  = 6'd11,
        OPC_ADDI = 6'd12, OPC_SUBI = 6'd13, OPC_SHRI = 6'd14, OPC_SHLI = 6'd15,
        OPC_ANDI = 6'd16, OPC_ORI  = 6'd17, OPC_XORI = 6'd18, OPC_LOAD = 6'd19,
        OPC_STOR = 6'd20, OPC_PUSH = 6'd21, OPC_POP  = 6'd22, OPC_JMP  = 6'd23,
        OPC_JAL  = 6'd24, OPC_JREL = 6'd25, OPC_BRE  = 6'd26, OPC_BRG  = 6'd27,
        OPC_BRU  = 6'd28, OPC_BRO  = 6'd29, OPC_RET  = 6'd30, OPC_NOP  = 6'd31
    } opcode_e;

    // packed: eq is bit 3, gt bit 2, unf bit 1, ovf bit 0
    typedef struct packed {
        logic eq;
        logic gt;
        logic unf;
        logic ovf;
    } flags_t;

    typedef enum logic [1:0] { AR_ADD, AR_SUB, AR_MUL } arith_e;

    typedef enum logic [1:0] { TG_ADDR, TG_JUMP, TG_REL, TG_BR } target_e;

    function automatic logic is_defined(input logic [5:0] code);
        return code[5] == 1'b0;
    endfunction

endpackage

// File: rtl/exu_arith.sv
module exu_arith
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  arith_e            kind,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res,
    output logic              ovf,
    output logic              unf
);
    localparam int PW = 2 * XLEN;

    logic [XLEN:0] sum_w;
    logic [XLEN:0] dif_w;
    logic [PW-1:0] prd_w;

    assign sum_w = {a[XLEN-1], a} + {b[XLEN-1], b};
    assign dif_w = {a[XLEN-1], a} - {b[XLEN-1], b};
    assign prd_w = {{XLEN{a[XLEN-1]}}, a} * {{XLEN{b[XLEN-1]}}, b};

    always_comb begin
        unique case (kind)
            AR_SUB: begin
                res = dif_w[XLEN-1:0];
                ovf = !dif_w[XLEN] &&  dif_w[XLEN-1];
                unf =  dif_w[XLEN] && !dif_w[XLEN-1];
            end
            AR_MUL: begin
                res = prd_w[XLEN-1:0];
                ovf = !prd_w[PW-1] &&  (|prd_w[PW-2:XLEN-1]);
                unf =  prd_w[PW-1] && !(&prd_w[PW-2:XLEN-1]);
            end
            default: begin
                res = sum_w[XLEN-1:0];
                ovf = !sum_w[XLEN] &&  sum_w[XLEN-1];
                unf =  sum_w[XLEN] && !sum_w[XLEN-1];
            end
        endcase
    end
endmodule

// File: rtl/exu_div.sv
module exu_div #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem,
    output logic            ovf,
    output logic            zero
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ONE      = {{(XLEN-1){1'b0}}, 1'b1};

    logic [XLEN-1:0] safe_b;
    logic            corner;

    assign zero   = (b == '0);
    assign corner = (a == MOST_NEG) && (b == '1);
    assign safe_b = (zero || corner) ? ONE : b;

    always_comb begin
        if (corner) begin
            quo = MOST_NEG;
            rem = MOST_NEG;
        end else begin
            quo = $unsigned($signed(a) / $signed(safe_b));
            rem = $unsigned($signed(a) % $signed(safe_b));
        end
    end

    assign ovf = corner;
endmodule

// File: rtl/exu_target.sv
module exu_target
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  target_e         kind,
    input  logic            cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] dest,
    output logic            taken
);
    always_comb begin
        taken = 1'b0;
        unique case (kind)
            TG_JUMP: dest = a + b;
            TG_REL:  dest = pc + b;
            TG_BR: begin
                taken = cond;
                dest  = cond ? (pc + b) : '1;
            end
            default: dest = a + imm;
        endcase
    end
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic [5:0]      opcode,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] result,
    output logic            br_taken,
    output logic            halt,
    output logic            illegal,
    output logic [3:0]      flags
);
    localparam int SHW = $clog2(XLEN);
    localparam logic [XLEN-1:0] MAX_POS = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] ONE     = {{(XLEN-1){1'b0}}, 1'b1};

    opcode_e         op;
    flags_t          flg_q;
    arith_e          ar_kind;
    logic [XLEN-1:0] ar_b, ar_res;
    logic            ar_ovf, ar_unf;
    logic [XLEN-1:0] dv_quo, dv_rem;
    logic            dv_ovf, dv_zero;
    target_e         tg_kind;
    logic            tg_cond, tg_taken;
    logic [XLEN-1:0] tg_res;
    logic [XLEN-1:0] res_c;
    logic [SHW-1:0]  shamt;
    logic            known, div_op, set_ou, set_cmp, use_tg, nxt_ovf, nxt_unf;

    assign op = opcode_e'(opcode);

    exu_arith #(.XLEN(XLEN)) u_arith (
        .kind(ar_kind), .a(op_a), .b(ar_b), .res(ar_res), .ovf(ar_ovf), .unf(ar_unf)
    );

    exu_div #(.XLEN(XLEN)) u_div (
        .a(op_a), .b(op_b), .quo(dv_quo), .rem(dv_rem), .ovf(dv_ovf), .zero(dv_zero)
    );

    exu_target #(.XLEN(XLEN)) u_target (
        .kind(tg_kind), .cond(tg_cond), .a(op_a), .b(op_b), .imm(imm), .pc(pc),
        .dest(tg_res), .taken(tg_taken)
    );

    always_comb begin
        known   = is_defined(opcode);
        res_c   = op_a;
        div_op  = 1'b0;
        set_ou  = 1'b0;
        set_cmp = 1'b0;
        use_tg  = 1'b0;
        nxt_ovf = flg_q.ovf;
        nxt_unf = flg_q.unf;
        ar_kind = AR_ADD;
        ar_b    = op_b;
        tg_kind = TG_ADDR;
        tg_cond = 1'b0;
        shamt   = op_b[SHW-1:0];
        unique case (op)
            OPC_ADD, OPC_SUB, OPC_MUL, OPC_ADDI, OPC_SUBI: begin
                ar_kind = (op == OPC_MUL) ? AR_MUL :
                          (op == OPC_SUB || op == OPC_SUBI) ? AR_SUB : AR_ADD;
                ar_b    = (op == OPC_ADDI || op == OPC_SUBI) ? imm : op_b;
                res_c   = ar_res;
                set_ou  = 1'b1;
                nxt_ovf = ar_ovf;
                nxt_unf = ar_unf;
            end
            OPC_QUO, OPC_REM: begin
                div_op  = 1'b1;
                res_c   = dv_zero ? MAX_POS : ((op == OPC_QUO) ? dv_quo : dv_rem);
                set_ou  = 1'b1;
                nxt_ovf = dv_ovf;
                nxt_unf = 1'b0;
            end
            OPC_AND, OPC_OR, OPC_XOR, OPC_NOT, OPC_ANDI, OPC_ORI, OPC_XORI: begin
                set_ou  = 1'b1;
                nxt_ovf = 1'b0;
                nxt_unf = 1'b0;
                unique case (op)
                    OPC_AND:  res_c = op_a & op_b;
                    OPC_OR:   res_c = op_a | op_b;
                    OPC_XOR:  res_c = op_a ^ op_b;
                    OPC_ANDI: res_c = op_a & imm;
                    OPC_ORI:  res_c = op_a | imm;
                    OPC_XORI: res_c = op_a ^ imm;
                    default:  res_c = ~op_a;
                endcase
            end
            OPC_SHR, OPC_SHL, OPC_SHRI, OPC_SHLI: begin
                if (op == OPC_SHRI || op == OPC_SHLI) shamt = imm[SHW-1:0];
                if (op == OPC_SHR || op == OPC_SHRI)
                    res_c = $unsigned($signed(op_a) >>> shamt);
                else
                    res_c = op_a << shamt;
            end
            OPC_CMP: set_cmp = 1'b1;
            OPC_LOAD, OPC_STOR, OPC_PUSH, OPC_POP: begin
                use_tg  = 1'b1;
                tg_kind = TG_ADDR;
            end
            OPC_JMP, OPC_JAL: begin
                use_tg  = 1'b1;
                tg_kind = TG_JUMP;
            end
            OPC_JREL: begin
                use_tg  = 1'b1;
                tg_kind = TG_REL;
            end
            OPC_BRE, OPC_BRG, OPC_BRU, OPC_BRO: begin
                use_tg  = 1'b1;
                tg_kind = TG_BR;
                tg_cond = (op == OPC_BRE) ? flg_q.eq  :
                          (op == OPC_BRG) ? flg_q.gt  :
                          (op == OPC_BRU) ? flg_q.unf : flg_q.ovf;
            end
            OPC_RET, OPC_NOP: ;
            default: known = 1'b0;
        endcase
        if (use_tg) res_c = tg_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else if (valid && known && !(div_op && dv_zero)) begin
            if (set_ou) begin
                flg_q.ovf <= nxt_ovf;
                flg_q.unf <= nxt_unf;
            end
            if (set_cmp) begin
                flg_q.gt <= $signed(op_a) > $signed(op_b);
                flg_q.eq <= op_a == op_b;
            end
        end
    end

    assign result   = res_c;
    assign br_taken = tg_taken;
    assign halt     = valid && div_op && dv_zero;
    assign illegal  = valid && !known;
    assign flags    = flg_q;

    // R1: largest positive plus one must raise positive overflow
    a_r1_add_overflow: assert property (@(posedge clk) disable iff (rst)
        (valid && opcode == 6'd0 && op_a == MAX_POS && op_b == ONE) |=> flags[0]);

    // R2: bitwise operations leave both overflow flags clear
    a_r2_logic_clears: assert property (@(posedge clk) disable iff (rst)
        (valid && opcode >= 6'd7 && opcode <= 6'd10) |=> (flags[1:0] == 2'b00));

    // R3: shifts keep every flag
    a_r3_shift_keeps: assert property (@(posedge clk) disable iff (rst)
        (valid && (opcode == 6'd5 || opcode == 6'd6 || opcode == 6'd14 || opcode == 6'd15))
        |=> $stable(flags));

    // R4: compare of equal operands sets equal and clears greater
    a_r4_cmp_equal: assert property (@(posedge clk) disable iff (rst)
        (valid && opcode == 6'd11 && op_a == op_b) |=> (flags[3] && !flags[2]));

    // R6: a branch not taken yields all ones
    a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
        (opcode >= 6'd26 && opcode <= 6'd29 && !br_taken) |-> (result == '1));

    // R8: halt forces the largest positive value and keeps flags
    a_r8_halt_max: assert property (@(posedge clk) disable iff (rst)
        halt |-> (result == MAX_POS));
    a_r8_halt_keeps: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(flags));

    // R9: illegal opcode keeps flags
    a_r9_illegal_keeps: assert property (@(posedge clk) disable iff (rst)
        illegal |=> $stable(flags));

    // R10: idle cycles keep flags
    a_r10_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(flags));
endmodule

// File: tb/exu_core_bench.sv
module exu_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam longint MAXL = 64'sd2147483647;
    localparam longint MINL = -64'sd2147483648;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic [5:0]    opcode = '0;
    logic [W-1:0]  op_a = '0, op_b = '0, imm = '0, pc = '0;
    logic [W-1:0]  result;
    logic          br_taken, halt, illegal;
    logic [3:0]    flags;

    int            n_run = 0;
    int            n_fail = 0;
    logic [3:0]    mf = 4'b0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exu_core #(.XLEN(W)) u_exu_core (
        .clk(clk), .rst(rst), .valid(valid), .opcode(opcode), .op_a(op_a),
        .op_b(op_b), .imm(imm), .pc(pc), .result(result), .br_taken(br_taken),
        .halt(halt), .illegal(illegal), .flags(flags)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op, input bit v);
        if (!v) return "R10";
        if (op >= 32) return "R9";
        case (op)
            0, 1, 2, 12, 13: return "R1";
            7, 8, 9, 10, 16, 17, 18: return "R2";
            5, 6, 14, 15: return "R3";
            11: return "R4";
            19, 20, 21, 22, 23, 24, 25: return "R5";
            26, 27, 28, 29: return "R6";
            3, 4: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] im, input logic [W-1:0] p, input bit v,
                         input logic [3:0] f, output logic [W-1:0] er, output logic et,
                         output logic eh, output logic ei, output logic [3:0] nf);
        longint sa, sb, si, t;
        bit c;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        si = longint'($signed(im));
        er = a; et = 1'b0; eh = 1'b0; ei = 1'b0; nf = f; t = 0;
        case (op)
            0, 1, 2, 12, 13: begin
                case (op)
                    0: t = sa + sb;
                    1: t = sa - sb;
                    2: t = sa * sb;
                    12: t = sa + si;
                    default: t = sa - si;
                endcase
                er = t[W-1:0];
                nf[0] = t > MAXL;
                nf[1] = t < MINL;
            end
            3, 4: begin
                if (b == 0) begin
                    er = 32'h7FFF_FFFF;
                    eh = v;
                end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
                    er = 32'h8000_0000;
                    nf[1:0] = 2'b01;
                end else begin
                    t = (op == 3) ? sa / sb : sa % sb;
                    er = t[W-1:0];
                    nf[1:0] = 2'b00;
                end
            end
            5:  begin t = sa >>> b[4:0];  er = t[W-1:0]; end
            6:  er = a << b[4:0];
            14: begin t = sa >>> im[4:0]; er = t[W-1:0]; end
            15: er = a << im[4:0];
            7:  begin er = a & b;  nf[1:0] = 2'b00; end
            8:  begin er = a | b;  nf[1:0] = 2'b00; end
            9:  begin er = a ^ b;  nf[1:0] = 2'b00; end
            10: begin er = ~a;     nf[1:0] = 2'b00; end
            16: begin er = a & im; nf[1:0] = 2'b00; end
            17: begin er = a | im; nf[1:0] = 2'b00; end
            18: begin er = a ^ im; nf[1:0] = 2'b00; end
            11: begin nf[2] = sa > sb; nf[3] = (sa == sb); end
            19, 20, 21, 22: er = a + im;
            23, 24: er = a + b;
            25: er = p + b;
            26, 27, 28, 29: begin
                c = (op == 26) ? f[3] : (op == 27) ? f[2] : (op == 28) ? f[1] : f[0];
                et = c;
                er = c ? p + b : 32'hFFFF_FFFF;
            end
            30, 31: ;
            default: ei = v;
        endcase
        if (!v) nf = f;
    endtask

    task automatic run_op(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] im, input logic [W-1:0] p, input bit v);
        logic [W-1:0] er;
        logic et, eh, ei;
        logic [3:0] nf;
        string tg;
        @(negedge clk);
        opcode = op[5:0]; op_a = a; op_b = b; imm = im; pc = p; valid = v;
        #1;
        tg = tag_of(op, v);
        model(op, a, b, im, p, v, mf, er, et, eh, ei, nf);
        if (v && (op == 3 || op == 4) && b == 0) tg = "R8";
        check(tg, "result", result, er);
        check(tg, "br_taken", {31'b0, br_taken}, {31'b0, et});
        check(tg, "halt", {31'b0, halt}, {31'b0, eh});
        check(tg, "illegal", {31'b0, illegal}, {31'b0, ei});
        @(posedge clk);
        #1;
        mf = nf;
        check(tg, "flags", {28'b0, flags}, {28'b0, mf});
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom_range(0, 11))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h0001_0000;
            6: return 32'($urandom_range(0, 40));
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", "reset flags", {28'b0, flags}, 32'h0);

        // R1 positive overflow, then clear; negative overflow on subtract
        run_op(0, 32'h7FFF_FFFF, 32'h1, 0, 0, 1);
        run_op(6, 32'h3, 32'h24, 0, 0, 1);               // R3 shift keeps OF, amt 4
        run_op(0, 32'hFFFF_FFFF, 32'h1, 0, 0, 1);
        run_op(1, 32'h8000_0000, 32'h1, 0, 0, 1);
        run_op(28, 0, 32'h40, 0, 32'h100, 1);            // R6 taken on UF
        run_op(29, 0, 32'h40, 0, 32'h100, 1);            // R6 not taken on OF
        run_op(2, 32'h0001_0000, 32'h0001_0000, 0, 0, 1);
        run_op(2, 32'h0001_0000, 32'hFFFF_0000, 0, 0, 1);
        run_op(12, 32'h7FFF_FFF0, 0, 32'h10, 0, 1);
        run_op(13, 32'h8000_0005, 0, 32'h6, 0, 1);
        run_op(10, 32'h0F0F_0000, 32'hFFFF, 0, 0, 1);    // R2 NOT ignores B
        run_op(5, 32'h8000_0010, 32'h23, 0, 0, 1);       // R3 arithmetic, amt 3
        run_op(14, 32'hF000_0000, 0, 32'hFFFF_FFE4, 0, 1);
        run_op(11, 32'h5, 32'hFFFF_FFFD, 0, 0, 1);       // R4 GT
        run_op(27, 0, 32'h8, 0, 32'h40, 1);
        run_op(11, 32'h9, 32'h9, 0, 0, 1);               // R4 EQ
        run_op(26, 0, 32'hFFFF_FFF0, 0, 32'h40, 1);
        run_op(27, 0, 32'h8, 0, 32'h40, 1);
        run_op(3, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 1);// R7 corner
        run_op(4, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 1);
        run_op(3, 32'hFFFF_FFF9, 32'h2, 0, 0, 1);
        run_op(4, 32'hFFFF_FFF9, 32'h2, 0, 0, 1);
        run_op(0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 1);
        run_op(3, 32'h1234, 32'h0, 0, 0, 1);             // R8 divide by zero
        run_op(40, 32'hABCD, 32'h1, 0, 0, 1);            // R9 illegal
        run_op(0, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);// R10 idle
        run_op(19, 32'h1000, 0, 32'hFFFF_FFFC, 0, 1);    // R5
        run_op(25, 0, 32'h20, 0, 32'h200, 1);
        run_op(24, 32'h300, 32'h4, 0, 0, 1);
        run_op(31, 32'h55, 32'h0, 0, 0, 1);

        for (int i = 0; i < 3000; i++) begin
            run_op(int'($urandom_range(0, 35)), pick(), pick(), pick(), $urandom,
                   ($urandom_range(0, 9) != 0));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule